// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block gathers eight peripheral request lines and presents one interrupt line to a processor. Each line is watched either for a rising transition or for a high level, depending on a single mode input. Lines can be masked individually. Among the unmasked requests that are not blocked by work already in progress, line 0 has the highest priority and line 7 the lowest.

The interrupt output is a live priority-encoder result. It is not a latch: if the only eligible request goes away, the output falls in the same cycle. The decision about which line to serve is made only when the processor pulses acknowledge. At that point the winning line is marked in service, and on the next cycle a vector made of a 5-bit base and the 3-bit line number is presented for one cycle.

If nothing is eligible when acknowledge arrives, the controller still answers. It returns the line-7 vector and marks nothing in service. A non-specific end-of-interrupt pulse retires the highest-priority line that is in service.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset `irq_o` is 0, `vec_valid_o` is 0 and no line is in service.
- R2: When `ack_i` is high for one cycle, `vec_valid_o` is high for exactly the next cycle. `vec_o` is then `{base_i, idx}`, where idx is the lowest-numbered eligible line at the acknowledge edge, and that line becomes in service.
- R3: In edge mode (`level_i`=0), a line seen high after being low makes `irq_o` rise in that same cycle. The line stays pending while it is held high.
- R4: In edge mode, a line that stays high through its acknowledge and end-of-interrupt raises no new interrupt. After it goes low and then high again, it does.
- R5: In level mode (`level_i`=1), a high line is a request. If it is still high when its end-of-interrupt is issued, `irq_o` rises again.
- R6: If a request drops before acknowledge, `irq_o` falls in that cycle. An acknowledge with no eligible line returns index 7 (`vec_o[2:0]`=7) and sets nothing in service.
- R7: A line whose `mask_i` bit is 1 neither drives `irq_o` nor can be chosen at acknowledge. A pending edge on it is honoured once the mask is cleared while the line is still high.
- R8: A line in service blocks requests from its own line and from all higher-numbered lines. Lower-numbered lines still raise `irq_o`.
- R9: An `eoi_i` pulse clears only the lowest-numbered in-service bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | 8 | Peripheral request lines, bit n is line n |
| level_i | input | 1 | 1: level detection, 0: rising-edge detection |
| mask_i | input | 8 | Per-line mask, 1 suppresses the line |
| base_i | input | 5 | Upper bits of the returned vector |
| ack_i | input | 1 | Single-cycle acknowledge from the processor |
| eoi_i | input | 1 | Single-cycle non-specific end-of-interrupt |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector `{base, line}` |
| vec_valid_o | output | 1 | High for the one cycle in which `vec_o` is fresh |

## Verification
`irq_o` is combinational from the request, mask and in-service state, so it is due in the same cycle as a request change. The vector and its valid flag are due on the cycle after the acknowledge edge. In-service changes from acknowledge or end-of-interrupt show on `irq_o` from the following cycle. The bench changes inputs 2 ns after the rising edge and samples on the falling edge, so each result is read in the cycle in which it is due.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int LINES = 8;
  localparam int IDX_W = $clog2(LINES);

  // isolate the lowest set bit (highest priority)
  function automatic logic [LINES-1:0] lowest_onehot(input logic [LINES-1:0] v);
    return v & (~v + LINES'(1));
  endfunction

  function automatic logic [IDX_W-1:0] onehot_idx(input logic [LINES-1:0] oh);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < LINES; i++)
      if (oh[i]) r = r | IDX_W'(i);
    return r;
  endfunction

  // a line is allowed when no line of equal or higher priority is in service
  function automatic logic [LINES-1:0] allow_from_isr(input logic [LINES-1:0] isr);
    logic [LINES-1:0] a;
    logic seen;
    seen = 1'b0;
    for (int i = 0; i < LINES; i++) begin
      seen = seen | isr[i];
      a[i] = ~seen;
    end
    return a;
  endfunction
endpackage

// File: rtl/irq_detect.sv
module irq_detect
  import irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] req_i,
  input  logic             level_i,
  input  logic [LINES-1:0] clr_i,
  output logic [LINES-1:0] cand_o
);
  logic [LINES-1:0] prev_q, pend_q, rise_w;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign rise_w[g] = req_i[g] & ~prev_q[g];
    assign cand_o[g] = level_i ? req_i[g] : ((pend_q[g] | rise_w[g]) & req_i[g]);

    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        prev_q[g] <= 1'b0;
        pend_q[g] <= 1'b0;
      end else begin
        prev_q[g] <= req_i[g];
        pend_q[g] <= level_i ? 1'b0
                             : ((pend_q[g] | rise_w[g]) & req_i[g] & ~clr_i[g]);
      end
    end
  end
endmodule

// File: rtl/irq_resolve.sv
module irq_resolve
  import irq_pkg::*;
(
  input  logic [LINES-1:0] cand_i,
  input  logic [LINES-1:0] mask_i,
  input  logic [LINES-1:0] isr_i,
  output logic [LINES-1:0] pick_o,
  output logic             any_o
);
  logic [LINES-1:0] elig_w;

  always_comb begin
    elig_w = cand_i & ~mask_i & allow_from_isr(isr_i);
    pick_o = lowest_onehot(elig_w);
    any_o  = |elig_w;
  end
endmodule

// File: rtl/irq_service.sv
module irq_service
  import irq_pkg::*;
#(
  parameter int BASE_W = 5,
  localparam int VEC_W = BASE_W + IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ack_i,
  input  logic              eoi_i,
  input  logic [LINES-1:0]  pick_i,
  input  logic              any_i,
  input  logic [BASE_W-1:0] base_i,
  output logic [LINES-1:0]  isr_o,
  output logic [LINES-1:0]  clr_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              vec_valid_o
);
  logic [LINES-1:0] isr_q, eoi_hit_w, set_w;
  logic [IDX_W-1:0] idx_w;

  assign eoi_hit_w = eoi_i ? lowest_onehot(isr_q) : '0;
  assign set_w     = (ack_i && any_i) ? pick_i : '0;
  assign clr_o     = set_w;
  assign idx_w     = any_i ? onehot_idx(pick_i) : IDX_W'(LINES - 1);
  assign isr_o     = isr_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      isr_q       <= '0;
      vec_o       <= '0;
      vec_valid_o <= 1'b0;
    end else begin
      isr_q       <= (isr_q & ~eoi_hit_w) | set_w;
      vec_valid_o <= ack_i;
      if (ack_i) vec_o <= {base_i, idx_w};
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int BASE_W = 5,
  localparam int VEC_W = BASE_W + IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINES-1:0]  req_i,
  input  logic              level_i,
  input  logic [LINES-1:0]  mask_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic              ack_i,
  input  logic              eoi_i,
  output logic              irq_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              vec_valid_o
);
  logic [LINES-1:0] cand_w, pick_w, isr_w, clr_w;
  logic             any_w;

  irq_detect u_detect (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .level_i(level_i),
    .clr_i(clr_w), .cand_o(cand_w)
  );

  irq_resolve u_resolve (
    .cand_i(cand_w), .mask_i(mask_i), .isr_i(isr_w),
    .pick_o(pick_w), .any_o(any_w)
  );

  irq_service #(.BASE_W(BASE_W)) u_service (
    .clk_i(clk_i), .rst_ni(rst_ni), .ack_i(ack_i), .eoi_i(eoi_i),
    .pick_i(pick_w), .any_i(any_w), .base_i(base_i), .isr_o(isr_w),
    .clr_o(clr_w), .vec_o(vec_o), .vec_valid_o(vec_valid_o)
  );

  assign irq_o = any_w;
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
  import irq_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ack_i,
  input logic             eoi_i,
  input logic             irq_o,
  input logic [LINES-1:0] req_i,
  input logic [LINES-1:0] mask_i,
  input logic [VEC_W-1:0] vec_o,
  input logic             vec_valid_o,
  input logic [LINES-1:0] isr,
  input logic [LINES-1:0] pick
);
  assert_vec_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> vec_valid_o);
  assert_vec_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |=> !vec_valid_o);
  assert_pick_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pick));
  assert_ack_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o && !eoi_i) |=> $countones(isr) == $past($countones(isr)) + 1);
  assert_spurious_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !irq_o && !eoi_i) |=> (vec_o[IDX_W-1:0] == IDX_W'(LINES - 1)) && $stable(isr));
  assert_live_req_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (req_i & ~mask_i) != '0);
  assert_masked_never_served_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> ((isr & ~$past(isr)) & $past(mask_i)) == '0);
  assert_eoi_one_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !ack_i && isr != '0) |=> $countones(isr) + 1 == $past($countones(isr)));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.VEC_W(VEC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ack_i(ack_i), .eoi_i(eoi_i), .irq_o(irq_o),
  .req_i(req_i), .mask_i(mask_i), .vec_o(vec_o), .vec_valid_o(vec_valid_o),
  .isr(isr_w), .pick(pick_w)
);

// File: tb/sim_irq_prio_ctrl.sv
`timescale 1ns/1ps
module sim_irq_prio_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req = '0, mask = '0;
  logic       level = 1'b0, ack = 1'b0, eoi = 1'b0;
  logic [4:0] base = 5'h0A;
  logic       irq, vld;
  logic [7:0] vec;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_prio_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .level_i(level), .mask_i(mask),
    .base_i(base), .ack_i(ack), .eoi_i(eoi), .irq_o(irq), .vec_o(vec),
    .vec_valid_o(vld)
  );

  // behavioural reference
  bit m_prev[8], m_pend[8], m_isr[8];
  int exp_vec = 0;
  bit exp_vld = 0;

  function automatic bit m_cand(int i);
    if (level) return req[i];
    return (m_pend[i] || (req[i] && !m_prev[i])) && req[i];
  endfunction

  function automatic int m_best();
    for (int i = 0; i < 8; i++) begin
      if (m_isr[i]) return -1;
      if (m_cand(i) && !mask[i]) return i;
    end
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin m_prev[i] = 0; m_pend[i] = 0; m_isr[i] = 0; end
      exp_vec = 0; exp_vld = 0;
    end else begin
      int s, e;
      bit np[8];
      s = m_best();
      e = -1;
      if (eoi) for (int i = 7; i >= 0; i--) if (m_isr[i]) e = i;
      for (int i = 0; i < 8; i++) np[i] = level ? 1'b0 : m_cand(i);
      if (ack) begin
        if (s >= 0) begin m_isr[s] = 1; np[s] = 0; exp_vec = base * 8 + s; end
        else exp_vec = base * 8 + 7;
      end
      exp_vld = ack;
      if (e >= 0) m_isr[e] = 0;
      for (int i = 0; i < 8; i++) begin m_pend[i] = np[i]; m_prev[i] = req[i]; end
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    check("R3 model irq_o", irq, (m_best() >= 0));
    check("R2 model vec_valid_o", vld, exp_vld);
    if (exp_vld) check("R2 model vec_o", vec, exp_vec);
  end

  task automatic after_edge(); @(posedge clk); #2; endtask
  task automatic pulse_ack(); after_edge(); ack = 1; after_edge(); ack = 0; @(negedge clk); endtask
  task automatic pulse_eoi(); after_edge(); eoi = 1; after_edge(); eoi = 0; @(negedge clk); endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    check("R1 irq_o after reset", irq, 0);
    check("R1 vec_valid_o after reset", vld, 0);

    // edge mode, single line
    after_edge(); req = 8'h08; @(negedge clk);
    check("R3 irq on rising edge", irq, 1);
    pulse_ack();
    check("R2 vec line3", vec, {5'h0A, 3'd3});
    check("R2 vec valid", vld, 1);
    pulse_eoi();
    check("R4 held line no retrigger", irq, 0);
    after_edge(); req = 8'h00;
    after_edge(); req = 8'h08; @(negedge clk);
    check("R4 retrigger after low-high", irq, 1);
    pulse_ack(); pulse_eoi();
    after_edge(); req = 8'h00;

    // priority, blocking, nesting, eoi order
    after_edge(); req = 8'h24; @(negedge clk);
    pulse_ack();
    check("R2 lowest line wins", vec[2:0], 2);
    check("R8 lower line blocked", irq, 0);
    pulse_eoi();
    check("R3 pending kept while high", irq, 1);
    pulse_ack();
    check("R2 second vec line5", vec[2:0], 5);
    after_edge(); req = 8'h26; @(negedge clk);
    check("R8 higher line nests", irq, 1);
    pulse_ack();
    check("R8 nested vec line1", vec[2:0], 1);
    after_edge(); req = 8'h2E; @(negedge clk);
    check("R8 line3 blocked by line1", irq, 0);
    pulse_eoi();
    check("R9 eoi retires line1 only", irq, 1);
    pulse_ack();
    check("R9 line3 served under line5", vec[2:0], 3);
    pulse_eoi(); pulse_eoi();
    after_edge(); req = 8'h00;

    // spurious
    after_edge(); req = 8'h10; @(negedge clk);
    check("R6 irq before drop", irq, 1);
    after_edge(); req = 8'h00; @(negedge clk);
    check("R6 irq falls on drop", irq, 0);
    pulse_ack();
    check("R6 spurious index", vec[2:0], 7);
    after_edge(); req = 8'h80; @(negedge clk);
    check("R6 line7 not in service", irq, 1);
    pulse_ack(); pulse_eoi();
    after_edge(); req = 8'h00;

    // masking
    after_edge(); mask = 8'h01; req = 8'h01; @(negedge clk);
    check("R7 masked no irq", irq, 0);
    pulse_ack();
    check("R7 masked not chosen", vec[2:0], 7);
    after_edge(); mask = 8'h00; @(negedge clk);
    check("R7 unmask honours pending", irq, 1);
    pulse_ack();
    check("R7 line0 after unmask", vec[2:0], 0);
    pulse_eoi();
    after_edge(); req = 8'h00;

    // level mode
    after_edge(); level = 1; base = 5'h1F; req = 8'h04; @(negedge clk);
    check("R5 level request", irq, 1);
    pulse_ack();
    check("R5 level vec", vec, {5'h1F, 3'd2});
    check("R8 own line blocked", irq, 0);
    pulse_eoi();
    check("R5 still high reasserts", irq, 1);
    pulse_ack();
    after_edge(); req = 8'h00;
    pulse_eoi();
    check("R5 low after eoi quiet", irq, 0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule